// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two two's complement operands over several clock cycles. The multiplicand width and the multiplier width are separate parameters. A one-cycle start pulse captures both operands into one working register. After that the block performs one Booth recoding step per clock. On the last step it raises a one-cycle done pulse and presents the exact signed product, which is M+N bits wide.

The working register places the multiplier between a zeroed upper field and one appended zero bit at the bottom. The two lowest bits of this register choose the action for each step. Bits 1:0 equal to 01 add the multiplicand, 10 adds its two's complement negation, and 00 or 11 add nothing. An arithmetic right shift by one bit follows each step. The upper field is one bit wider than the multiplicand. This guard bit lets the negation of the most negative multiplicand be represented, so that case still gives the exact product.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy is 0, done is 0 and product is 0.
- R2: A start sampled while idle loads the operands on that clock edge. Done rises on the Nth rising edge after it, so a result takes N+1 cycles including the load.
- R3: Done is high for exactly one cycle per operation.
- R4: Product equals the exact signed product of the captured operands. This holds for every pair, including most negative times most negative, -1 times most negative, and zero operands.
- R5: Product changes only on the edge that raises done, and otherwise holds its value until the next result.
- R6: A start sampled while busy is ignored. The running operation completes with its original operands and its original timing.
- R7: Busy is 1 from the edge after the load until the edge that raises done, and busy is 0 whenever done is 1.
- R8: R2 to R5 hold when the multiplier width differs from the multiplicand width (M=8, N=5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin; ignored while busy |
| mcand | input | M | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when product is updated |
| product | output | M+N | Signed product of the last completed operation |

## Verification
The hardest case to bring about is the negation of a most negative multiplicand. It only matters when the multiplier's bit pattern selects the subtract action, and it only overflows without the guard bit when the accumulated partial sum is already near its limit. Directed pairs cover this: most negative by most negative, most negative by -1, and most negative by alternating-bit multipliers. These pairs drive subtract steps with the extreme multiplicand at both the first and the last step. A second case, which is also hard to reach, is a start arriving mid-run with different operands. The stimulus raises start with altered operands several cycles into an operation and then checks that the original product and timing are unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOP_HOLD = 2'd0,
    BOP_ADD  = 2'd1,
    BOP_SUB  = 2'd2
  } booth_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;

  // Radix-2 recoding of the two lowest working-register bits.
  function automatic booth_op_e booth_decode(input logic [1:0] pair);
    booth_op_e op;
    case (pair)
      2'b01:   op = BOP_ADD;
      2'b10:   op = BOP_SUB;
      default: op = BOP_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_operand_prep.sv
module booth_operand_prep #(
  parameter int M = 8,
  parameter int N = 8,
  localparam int W = M + N + 2
) (
  input  logic [M-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [W-1:0] add_val,
  output logic [W-1:0] sub_val,
  output logic [W-1:0] init_val
);

  // Sign-extend the multiplicand by one guard bit.
  function automatic logic [M:0] guard_ext(input logic [M-1:0] x);
    return {x[M-1], x};
  endfunction

  // Two's complement negation: invert all bits, then add one.
  function automatic logic [M:0] twos_neg(input logic [M:0] x);
    return (~x) + {{M{1'b0}}, 1'b1};
  endfunction

  logic [M:0] mc_ext;
  logic [M:0] mc_neg;

  always_comb begin
    mc_ext   = guard_ext(mcand);
    mc_neg   = twos_neg(mc_ext);
    add_val  = {mc_ext, {(N+1){1'b0}}};
    sub_val  = {mc_neg, {(N+1){1'b0}}};
    init_val = {{(M+1){1'b0}}, mplier, 1'b0};
  end

endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] work,
  input  logic [W-1:0] add_val,
  input  logic [W-1:0] sub_val,
  output booth_op_e    op,
  output logic [W-1:0] next
);

  logic [W-1:0] addend;
  logic [W-1:0] sum;

  always_comb begin
    op = booth_decode(work[1:0]);
    case (op)
      BOP_ADD: addend = add_val;
      BOP_SUB: addend = sub_val;
      default: addend = '0;
    endcase
    sum  = work + addend;
    next = W'($signed(sum) >>> 1);
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          step_en,
  output logic          last,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] step_cnt
);

  booth_state_e state_q;
  logic         done_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    load     = start && (state_q == ST_IDLE);
    step_en  = (state_q == ST_RUN);
    last     = step_en && (cnt_q == CW'(N - 1));
    busy     = step_en;
    done     = done_q;
    step_cnt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_en) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int M = 8,
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [M-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [M+N-1:0] product
);

  localparam int W  = M + N + 2;
  localparam int CW = $clog2(N + 1);

  logic [W-1:0]  add_in, sub_in, init_in;
  logic [W-1:0]  add_q, sub_q, work_q;
  logic [W-1:0]  work_next;
  logic [M+N-1:0] product_q;
  booth_op_e     step_op;
  logic          load, step_en, last;
  logic [CW-1:0] step_cnt;

  booth_operand_prep #(.M(M), .N(N)) u_prep (
    .mcand   (mcand),
    .mplier  (mplier),
    .add_val (add_in),
    .sub_val (sub_in),
    .init_val(init_in)
  );

  booth_step #(.W(W)) u_step (
    .work   (work_q),
    .add_val(add_q),
    .sub_val(sub_q),
    .op     (step_op),
    .next   (work_next)
  );

  booth_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .load    (load),
    .step_en (step_en),
    .last    (last),
    .busy    (busy),
    .done    (done),
    .step_cnt(step_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q    <= '0;
      add_q     <= '0;
      sub_q     <= '0;
      product_q <= '0;
    end else if (load) begin
      work_q <= init_in;
      add_q  <= add_in;
      sub_q  <= sub_in;
    end else if (step_en) begin
      work_q <= work_next;
      if (last) product_q <= work_next[M+N:1];
    end
  end

  assign product = product_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk
  import booth_pkg::*;
#(
  parameter int M = 8,
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [M+N-1:0] product,
  input logic           step_en,
  input logic [CW-1:0]  step_cnt,
  input booth_op_e      step_op
);

  logic [CW:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  a_r2_step_count: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (run_len == (CW+1)'(N)));

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && step_cnt == '0));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_product_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && step_cnt != CW'(N - 1)) |=>
      (busy && step_cnt == CW'($past(step_cnt) + 1'b1)));

  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r7_op_legal: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (step_op != 2'd3));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.M(M), .N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product),
  .step_en (step_en),
  .step_cnt(step_cnt),
  .step_op (step_op)
);

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        start_a, busy_a, done_a;
  logic [7:0]  mc_a, mp_a;
  logic [15:0] prod_a;
  logic        start_b, busy_b, done_b;
  logic [7:0]  mc_b;
  logic [4:0]  mp_b;
  logic [12:0] prod_b;

  int errors = 0;
  int checks = 0;

  booth_seq_mult #(.M(8), .N(8)) i_booth_seq_mult (
    .clk(clk), .rst(rst), .start(start_a), .mcand(mc_a), .mplier(mp_a),
    .busy(busy_a), .done(done_a), .product(prod_a));

  booth_seq_mult #(.M(8), .N(5)) i_booth_seq_mult_n5 (
    .clk(clk), .rst(rst), .start(start_b), .mcand(mc_b), .mplier(mp_b),
    .busy(busy_b), .done(done_b), .product(prod_b));

  function automatic longint ref_mul(input longint a, input longint b);
    return a * b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 8x8 instance; disturb raises start with other operands mid-run (R6)
  task automatic run_a(input logic [7:0] x, input logic [7:0] y, input bit disturb);
    int cyc;
    logic [15:0] held;
    longint exp;
    exp = ref_mul(longint'($signed(x)), longint'($signed(y)));
    @(negedge clk);
    mc_a = x; mp_a = y; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    cyc = 1;
    while (!done_a && cyc < 40) begin
      if (cyc == 2) check(busy_a == 1'b1, "R7", "busy during run", longint'(busy_a), 1);
      if (disturb && cyc == 4) begin
        start_a = 1'b1; mc_a = ~x; mp_a = y ^ 8'h5A;
      end else begin
        start_a = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_a = 1'b0;
    check(cyc == 9, disturb ? "R6" : "R2", "latency", longint'(cyc), 9);
    check(busy_a == 1'b0, "R7", "busy with done", longint'(busy_a), 0);
    check(longint'($signed(prod_a)) == exp, disturb ? "R6" : "R4", "product",
          longint'($signed(prod_a)), exp);
    held = prod_a;
    @(negedge clk);
    check(done_a == 1'b0, "R3", "done pulse width", longint'(done_a), 0);
    check(prod_a == held, "R5", "product hold", longint'(prod_a), longint'(held));
  endtask

  // 8x5 instance (R8)
  task automatic run_b(input logic [7:0] x, input logic [4:0] y);
    int cyc;
    longint exp;
    exp = ref_mul(longint'($signed(x)), longint'($signed(y)));
    @(negedge clk);
    mc_b = x; mp_b = y; start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    cyc = 1;
    while (!done_b && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 6, "R8", "latency N=5", longint'(cyc), 6);
    check(longint'($signed(prod_b)) == exp, "R8", "product N=5",
          longint'($signed(prod_b)), exp);
    @(negedge clk);
    check(done_b == 1'b0, "R8", "done pulse N=5", longint'(done_b), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h0000_B007);
    rst = 1'b1; start_a = 0; start_b = 0;
    mc_a = 0; mp_a = 0; mc_b = 0; mp_b = 0;
    repeat (3) @(negedge clk);
    check(!busy_a && !done_a && prod_a == 0, "R1", "reset state a", longint'(prod_a), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_a && !done_a && prod_a == 0, "R1", "after reset a", longint'(prod_a), 0);
    check(!busy_b && !done_b && prod_b == 0, "R1", "after reset b", longint'(prod_b), 0);

    // Directed extremes (R4)
    run_a(8'h80, 8'h80, 0);
    run_a(8'hFF, 8'h80, 0);
    run_a(8'h80, 8'hFF, 0);
    run_a(8'h00, 8'h80, 0);
    run_a(8'h7F, 8'h00, 0);
    run_a(8'h7F, 8'h7F, 0);
    run_a(8'h80, 8'h7F, 0);
    run_a(8'h80, 8'h55, 0);
    run_a(8'h80, 8'hAA, 0);
    run_a(8'h80, 8'h01, 0);
    // Start while busy (R6)
    run_a(8'h93, 8'h6C, 1);
    run_a(8'h80, 8'h80, 1);
    for (int i = 0; i < 300; i++) run_a(8'($urandom), 8'($urandom), (i % 37) == 0);

    // Unequal widths (R8)
    run_b(8'h80, 5'h10);
    run_b(8'hFF, 5'h10);
    run_b(8'h80, 5'h1F);
    run_b(8'h7F, 5'h0F);
    run_b(8'h00, 5'h15);
    for (int i = 0; i < 300; i++) run_b(8'($urandom), 5'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule